// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware part of taking an interrupt. When a request is pending and the global interrupt enable is set, it clears the enable and captures the current program counter, condition code byte, stack pointer and vector number. It then runs a fixed series of memory accesses through a single byte/word memory port. Two chained word reads find the handler address: the vector slot holds a pointer, and the word at that pointer is the handler. A word write then pushes the program counter onto a descending stack. Two byte writes place the condition code byte in both halves of the next stack word.

After the last access, the block presents the handler address as the new program counter and the stack pointer lowered by four. It raises a one-cycle done strobe at the same time. Words are big-endian: the high byte sits at the even address. Every access waits for the memory ready handshake. The enable stays clear until the surrounding core pulses the set input, so further requests are not taken until then.

Top module: `irq_entry_seq`

## Requirements
- R1: When `irq_req` is 1, `gie` is 1 and the block is idle, entry starts on that clock edge and `gie` reads 0 from the next cycle. A request while `gie` is 0 produces no memory access and no `done`. A request while a sequence is running is also ignored.
- R2: After reset, `gie`, `done` and `mem_req` are 0. A one-cycle pulse on `gie_set` makes `gie` 1 from the next cycle.
- R3: The first access is a word read (`mem_we`=0, `mem_word`=1) at the vector number shifted left by one and zero-extended. The low address-width bits of the read data are taken as a pointer.
- R4: The second access is a word read at that pointer. Its data is taken as the handler address.
- R5: The third access is a word write (`mem_we`=1, `mem_word`=1) of the captured PC at SP-2. The PC's high byte is stored at SP-2 and its low byte at SP-1.
- R6: The fourth access is a byte write (`mem_word`=0, data on `mem_wdata[7:0]`) of the captured CCR at SP-4. The fifth is the same byte written at SP-3.
- R7: An access is requested with `mem_req`=1 and completes on the edge where `mem_rdy` is also 1. Until then, its address, direction, size and write data stay unchanged. At most one access completes per cycle, and exactly five complete per entry.
- R8: PC, CCR, SP and vector number are captured on the start edge. Changes to those inputs afterwards have no effect on the sequence.
- R9: `done` is 1 for exactly one cycle: the cycle after the fifth access completes. From that cycle on, `pc_out` equals the handler address and `sp_out` equals SP-4, and both hold until the next entry finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request pending |
| irq_vec | input | VW | Vector number of the request |
| gie_set | input | 1 | Pulse that sets the global interrupt enable |
| cur_pc | input | DW | Current program counter |
| cur_ccr | input | CW | Current condition code byte |
| cur_sp | input | AW | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data (a byte uses bits 7:0) |
| mem_rdata | input | DW | Read data, big-endian word |
| mem_rdy | input | 1 | Memory ready, completes the current access |
| gie | output | 1 | Global interrupt enable |
| pc_out | output | DW | Handler address loaded as the new PC |
| sp_out | output | AW | Stack pointer after the pushes |
| done | output | 1 | One-cycle strobe when the new PC is loaded |

## Verification
A wrong state register would show up at the memory port within one access. It would appear as a misordered access, a wrong address or size, an extra or missing access, or a request that changes before `mem_rdy`. The bench logs every completed access and compares it in order against the expected five. It sweeps every vector number against several ready patterns. A wrong capture or pointer register is seen in the stacked bytes and in `pc_out` at the `done` cycle. A wrong enable register is seen as a sequence that starts without permission, or as `gie` still high after entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_HND,
        ST_PCW,
        ST_CCH,
        ST_CCL,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RD_W,
        ACC_WR_W,
        ACC_WR_B
    } acc_kind_e;

    // state that follows a completed access
    function automatic seq_state_e step_after(input seq_state_e s);
        case (s)
            ST_VEC:  return ST_HND;
            ST_HND:  return ST_PCW;
            ST_PCW:  return ST_CCH;
            ST_CCH:  return ST_CCL;
            ST_CCL:  return ST_FIN;
            default: return ST_IDLE;
        endcase
    endfunction

    function automatic acc_kind_e kind_of(input seq_state_e s);
        case (s)
            ST_VEC, ST_HND:  return ACC_RD_W;
            ST_PCW:          return ACC_WR_W;
            ST_CCH, ST_CCL:  return ACC_WR_B;
            default:         return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_gie_reg.sv
module irq_gie_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic gie_o
);
    always_ff @(posedge clk) begin
        if (rst)
            gie_o <= 1'b0;
        else if (clr_i)
            gie_o <= 1'b0;
        else if (set_i)
            gie_o <= 1'b1;
    end
endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  acc_kind_e       kind_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   data_i,
    input  logic            rdy_i,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_word,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            fire_o
);
    always_comb begin
        mem_req   = (kind_i != ACC_NONE);
        mem_we    = (kind_i == ACC_WR_W) || (kind_i == ACC_WR_B);
        mem_word  = (kind_i == ACC_RD_W) || (kind_i == ACC_WR_W);
        mem_addr  = mem_req ? addr_i : '0;
        mem_wdata = mem_we ? data_i : '0;
        fire_o    = mem_req && rdy_i;
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int VW = 7,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [VW-1:0]   vec_i,
    input  logic [DW-1:0]   pc_i,
    input  logic [CW-1:0]   ccr_i,
    input  logic [AW-1:0]   sp_i,
    input  logic            fire_i,
    input  logic [DW-1:0]   rdata_i,
    output acc_kind_e       kind_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   data_o,
    output logic [DW-1:0]   pc_o,
    output logic [AW-1:0]   sp_o,
    output logic            done_o,
    output logic            busy_o
);
    localparam int VPAD = AW - VW - 1;
    localparam int CPAD = DW - CW;

    seq_state_e      state;
    logic [VW-1:0]   cap_vec;
    logic [DW-1:0]   cap_pc;
    logic [CW-1:0]   cap_ccr;
    logic [AW-1:0]   cap_sp;
    logic [AW-1:0]   ptr;
    logic [DW-1:0]   hnd;
    logic [AW-1:0]   sp_m2;
    logic [AW-1:0]   sp_m4;

    assign sp_m2 = cap_sp - AW'(2);
    assign sp_m4 = cap_sp - AW'(4);

    always_comb begin
        kind_o = kind_of(state);
        addr_o = '0;
        data_o = '0;
        case (state)
            ST_VEC: addr_o = {{VPAD{1'b0}}, cap_vec, 1'b0};
            ST_HND: addr_o = ptr;
            ST_PCW: begin
                addr_o = sp_m2;
                data_o = cap_pc;
            end
            ST_CCH: begin
                addr_o = sp_m4;
                data_o = {{CPAD{1'b0}}, cap_ccr};
            end
            ST_CCL: begin
                addr_o = sp_m4 + AW'(1);
                data_o = {{CPAD{1'b0}}, cap_ccr};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cap_vec <= '0;
            cap_pc  <= '0;
            cap_ccr <= '0;
            cap_sp  <= '0;
            ptr     <= '0;
            hnd     <= '0;
            pc_o    <= '0;
            sp_o    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cap_vec <= vec_i;
                        cap_pc  <= pc_i;
                        cap_ccr <= ccr_i;
                        cap_sp  <= sp_i;
                        state   <= ST_VEC;
                    end
                end
                ST_FIN: state <= ST_IDLE;
                default: begin
                    if (fire_i) begin
                        if (state == ST_VEC) ptr <= rdata_i[AW-1:0];
                        if (state == ST_HND) hnd <= rdata_i;
                        if (state == ST_CCL) begin
                            pc_o <= hnd;
                            sp_o <= sp_m4;
                        end
                        state <= step_after(state);
                    end
                end
            endcase
        end
    end

    assign done_o = (state == ST_FIN);
    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int VW = 7,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req,
    input  logic [VW-1:0]   irq_vec,
    input  logic            gie_set,
    input  logic [DW-1:0]   cur_pc,
    input  logic [CW-1:0]   cur_ccr,
    input  logic [AW-1:0]   cur_sp,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_word,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rdy,
    output logic            gie,
    output logic [DW-1:0]   pc_out,
    output logic [AW-1:0]   sp_out,
    output logic            done
);
    acc_kind_e       kind;
    logic [AW-1:0]   acc_addr;
    logic [DW-1:0]   acc_data;
    logic            fire;
    logic            busy;
    logic            start;

    assign start = irq_req && gie && !busy;

    irq_gie_reg u_gie (
        .clk   (clk),
        .rst   (rst),
        .set_i (gie_set),
        .clr_i (start),
        .gie_o (gie)
    );

    irq_entry_ctrl #(.AW(AW), .DW(DW), .VW(VW), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .vec_i   (irq_vec),
        .pc_i    (cur_pc),
        .ccr_i   (cur_ccr),
        .sp_i    (cur_sp),
        .fire_i  (fire),
        .rdata_i (mem_rdata),
        .kind_o  (kind),
        .addr_o  (acc_addr),
        .data_o  (acc_data),
        .pc_o    (pc_out),
        .sp_o    (sp_out),
        .done_o  (done),
        .busy_o  (busy)
    );

    irq_mem_port #(.AW(AW), .DW(DW)) u_port (
        .kind_i    (kind),
        .addr_i    (acc_addr),
        .data_i    (acc_data),
        .rdy_i     (mem_rdy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fire_o    (fire)
    );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_req,
    input logic            gie,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic            mem_rdy,
    input logic            mem_we,
    input logic            mem_word,
    input logic [AW-1:0]   mem_addr,
    input logic [DW-1:0]   mem_wdata
);
    AST_START_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
        (irq_req && gie && !busy) |=> (!gie && busy)); // R1

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R1

    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_word) && $stable(mem_wdata))); // R7

    AST_READ_IS_WORD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_word && !mem_addr[0])); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R9
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .gie       (gie),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_we    (mem_we),
    .mem_word  (mem_word),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int VW = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_req = 1'b0;
    logic [VW-1:0] irq_vec = '0;
    logic gie_set = 1'b0;
    logic [DW-1:0] cur_pc = '0;
    logic [CW-1:0] cur_ccr = '0;
    logic [AW-1:0] cur_sp = '0;
    logic mem_req, mem_we, mem_word, gie, done;
    logic [AW-1:0] mem_addr, sp_out;
    logic [DW-1:0] mem_wdata, mem_rdata, pc_out;
    logic mem_rdy = 1'b0;

    always #5 clk = ~clk;

    irq_entry_seq #(.AW(AW), .DW(DW), .VW(VW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
        .gie_set(gie_set), .cur_pc(cur_pc), .cur_ccr(cur_ccr), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .gie(gie), .pc_out(pc_out), .sp_out(sp_out),
        .done(done)
    );

    // byte memory, big-endian words
    logic [7:0] mem [0:255];
    assign mem_rdata = {mem[mem_addr], mem[8'(mem_addr + 8'd1)]};

    int log_n;
    logic [AW-1:0] log_addr [0:15];
    logic log_we [0:15];
    logic log_word [0:15];
    logic [DW-1:0] log_data [0:15];

    always @(posedge clk) begin
        if (!rst && mem_req && mem_rdy) begin
            if (log_n < 16) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
                log_word[log_n] = mem_word;
                log_data[log_n] = mem_wdata;
            end
            log_n = log_n + 1;
            if (mem_we) begin
                if (mem_word) begin
                    mem[mem_addr] <= mem_wdata[15:8];
                    mem[8'(mem_addr + 8'd1)] <= mem_wdata[7:0];
                end else begin
                    mem[mem_addr] <= mem_wdata[7:0];
                end
            end
        end
    end

    // ready pattern: high every (rdy_pat+1)th cycle
    int rdy_pat = 0;
    int rdy_cnt = 0;
    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        mem_rdy <= ((rdy_cnt % (rdy_pat + 1)) == 0);
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    function automatic logic [AW-1:0] ptr_of(input int v);
        return 8'(8'h40 + 2 * v);
    endfunction
    function automatic logic [DW-1:0] hnd_of(input int v);
        return 16'hC000 ^ 16'(v * 16'h0123);
    endfunction

    task automatic run_entry(input int v, input int pat, input int run, input bit hold);
        logic [DW-1:0] pc;
        logic [CW-1:0] ccr;
        logic [AW-1:0] sp;
        int waited;
        int ones;
        pc  = 16'h1234 + 16'(run * 16'h0101);
        ccr = 8'h5A ^ 8'(run);
        sp  = 8'hF0 - 8'(pat * 16);
        @(negedge clk);
        rdy_pat = pat;
        log_n = 0;
        gie_set = 1'b1;
        irq_vec = VW'(v);
        cur_pc = pc;
        cur_ccr = ccr;
        cur_sp = sp;
        @(negedge clk);
        gie_set = 1'b0;
        chk("R2 gie set", 32'(gie), 32'd1);
        irq_req = 1'b1;
        @(negedge clk);
        chk("R1 gie cleared on start", 32'(gie), 32'd0);
        // R8: scramble inputs after the start edge
        cur_pc = ~pc;
        cur_ccr = ~ccr;
        cur_sp = sp - 8'd32;
        irq_vec = ~VW'(v);
        if (!hold) irq_req = 1'b0;
        waited = 0;
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk("R9 done seen", 32'(done), 32'd1);
        chk("R9 pc_out handler", 32'(pc_out), 32'(hnd_of(v)));
        chk("R9 sp_out", 32'(sp_out), 32'(8'(sp - 8'd4)));
        chk("R7 access count", 32'(log_n), 32'd5);
        chk("R3 vec addr", 32'(log_addr[0]), 32'(2 * v));
        chk("R3 vec word read", 32'({log_we[0], log_word[0]}), 32'b01);
        chk("R4 hnd addr", 32'(log_addr[1]), 32'(ptr_of(v)));
        chk("R4 hnd word read", 32'({log_we[1], log_word[1]}), 32'b01);
        chk("R5 pc push addr", 32'(log_addr[2]), 32'(8'(sp - 8'd2)));
        chk("R5 pc push word write", 32'({log_we[2], log_word[2]}), 32'b11);
        chk("R6 ccr hi addr", 32'(log_addr[3]), 32'(8'(sp - 8'd4)));
        chk("R6 ccr lo addr", 32'(log_addr[4]), 32'(8'(sp - 8'd3)));
        chk("R6 ccr byte writes", 32'({log_we[3], log_word[3], log_we[4], log_word[4]}), 32'b1010);
        chk("R5 stack pc hi", 32'(mem[8'(sp - 8'd2)]), 32'(pc[15:8]));
        chk("R5 stack pc lo", 32'(mem[8'(sp - 8'd1)]), 32'(pc[7:0]));
        chk("R6 stack ccr even", 32'(mem[8'(sp - 8'd4)]), 32'(ccr));
        chk("R6 stack ccr odd", 32'(mem[8'(sp - 8'd3)]), 32'(ccr));
        chk("R1 gie low after entry", 32'(gie), 32'd0);
        ones = 0;
        repeat (3) begin
            @(negedge clk);
            if (done) ones++;
        end
        chk("R9 done single cycle", 32'(ones), 32'd0);
        chk("R9 pc_out held", 32'(pc_out), 32'(hnd_of(v)));
        chk("R1 no access after entry", 32'(log_n), 32'd5);
        irq_req = 1'b0;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 3);
        for (int v = 0; v < 16; v++) begin
            mem[2 * v]     = 8'h00;
            mem[2 * v + 1] = ptr_of(v);
            mem[ptr_of(v)]      = hnd_of(v)[15:8];
            mem[ptr_of(v) + 1]  = hnd_of(v)[7:0];
        end
        log_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset gie", 32'(gie), 32'd0);
        chk("R2 reset done", 32'(done), 32'd0);
        chk("R2 reset mem_req", 32'(mem_req), 32'd0);
        // R1: request with enable low is ignored
        irq_req = 1'b1;
        irq_vec = 4'd3;
        repeat (8) begin
            @(negedge clk);
            chk("R1 ignored without gie", 32'({mem_req, done}), 32'd0);
        end
        irq_req = 1'b0;
        begin
            int run;
            run = 0;
            for (int pat = 0; pat < 3; pat++) begin
                for (int v = 0; v < 16; v++) begin
                    run_entry(v, pat, run, (v % 2) == 1);
                    run++;
                end
            end
        end
        finish_up();
    end
endmodule